// File: doc/BRIEF.md
# CSR Instruction Access Controller

This block carries out the six control-and-status-register instructions: swap, set-bits and clear-bits, each with a register operand or a 5-bit zero-extended immediate. A decoded instruction arrives as one strobe. It carries the function code, the destination and source register indices, the source register value, the 12-bit register address and the hart's current privilege level. The block then decides whether the instruction reads the register, whether it writes it, and whether it must fault. It drives a read and write port toward an external register bank and returns either the old register value for the destination or an illegal-instruction fault.

Two rules decide whether an access takes place, and both depend on operand indices being zero. A swap with destination x0 skips the read, so any read side effect is avoided. A set or clear with source x0, or with a zero immediate, skips the write. The read-only check applies only when a write would really happen, so a read of a read-only register with a zero operand succeeds.

Each instruction is serializing. While one is in flight the block accepts no other instruction. The bank write is committed before the response is given, and so before any following instruction can reach the bank.

Top module: `csr_access_ctrl`

## Requirements
- R1: After reset, busy, the bank read strobe, the bank write strobe, the response strobe, the fault flag and the writeback enable are all low.
- R2: For the swap forms (function codes 1 and 5), the bank is read only when the destination index is nonzero, and it is written whenever the instruction does not fault.
- R3: For register set and clear (codes 2 and 3), the bank is always read, and it is written only when the source index is nonzero.
- R4: For immediate set and clear (codes 6 and 7), the write happens only when the 5-bit immediate (the source index field) is nonzero. Every immediate is zero-extended to the register width.
- R5: The write data is the operand for a swap, the old value OR the operand for a set, and the old value AND NOT the operand for a clear.
- R6: When the privilege level (0 user, 1 supervisor, 3 machine) is numerically below address bits 9:8, the instruction faults and raises neither bank strobe.
- R7: When a write would occur and address bits 11:10 are 2'b11, the instruction faults. A read-only address accessed without a write does not fault.
- R8: An address that the bank reports as absent causes a fault.
- R9: An instruction accepted at a clock edge holds busy and drives the bank strobes for the next cycle. The response lasts one cycle and follows in the cycle after that. A strobe that arrives while busy is high is ignored.
- R10: Without a fault, the writeback enable is high exactly when the destination index is nonzero. The writeback data is the old value sign-extended from XLEN to RD_W bits, and it is zero when the read was skipped.
- R11: Function codes 0 and 4 cause a fault. A fault response never raises the writeback enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction strobe |
| op_funct | input | 3 | Function code: bit 2 selects the immediate form, bits 1:0 select swap, set or clear |
| op_rd | input | 5 | Destination register index |
| op_rs1 | input | 5 | Source register index, or the 5-bit immediate |
| op_rs1_val | input | XLEN | Source register value |
| op_addr | input | 12 | Register address |
| op_priv | input | 2 | Current privilege level |
| busy | output | 1 | Instruction in flight; new strobes are ignored |
| csr_addr | output | 12 | Bank address |
| csr_rd_en | output | 1 | Bank read strobe, the read side effect |
| csr_rd_data | input | XLEN | Bank read data |
| csr_present | input | 1 | Bank reports that the address exists |
| csr_wr_en | output | 1 | Bank write strobe |
| csr_wr_data | output | XLEN | Bank write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | Illegal-instruction fault |
| rd_we | output | 1 | Destination writeback enable |
| rd_idx | output | 5 | Destination index |
| rd_data | output | RD_W | Writeback value |

## Verification
The hardest cases to reach are those where the zero-index rules and the read-only check interact. A read-only register must be reachable without a fault through a set with a zero source or a zero immediate. The same register must fault as soon as a nonzero operand makes the write real. The stimulus pairs these accesses on the same read-only addresses and checks the strobes in the access cycle, so a skipped read or a skipped write shows up directly. A second instruction is also driven during the busy cycle to show that it leaves the bank untouched.

// File: rtl/csr_access_ctrl.sv
module csr_access_ctrl #(
  parameter int XLEN = 32,
  parameter int RD_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [2:0]      op_funct,
  input  logic [4:0]      op_rd,
  input  logic [4:0]      op_rs1,
  input  logic [XLEN-1:0] op_rs1_val,
  input  logic [11:0]     op_addr,
  input  logic [1:0]      op_priv,
  output logic            busy,
  output logic [11:0]     csr_addr,
  output logic            csr_rd_en,
  input  logic [XLEN-1:0] csr_rd_data,
  input  logic            csr_present,
  output logic            csr_wr_en,
  output logic [XLEN-1:0] csr_wr_data,
  output logic            rsp_valid,
  output logic            rsp_fault,
  output logic            rd_we,
  output logic [4:0]      rd_idx,
  output logic [RD_W-1:0] rd_data
);
  localparam int EXT = RD_W - XLEN;

  logic            busy_q;
  logic [2:0]      funct_q;
  logic [4:0]      rd_q, rs1_q;
  logic [XLEN-1:0] val_q;
  logic [11:0]     addr_q;
  logic [1:0]      priv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      funct_q <= '0;
      rd_q    <= '0;
      rs1_q   <= '0;
      val_q   <= '0;
      addr_q  <= '0;
      priv_q  <= '0;
    end else if (!busy_q && op_valid) begin
      busy_q  <= 1'b1;
      funct_q <= op_funct;
      rd_q    <= op_rd;
      rs1_q   <= op_rs1;
      val_q   <= op_rs1_val;
      addr_q  <= op_addr;
      priv_q  <= op_priv;
    end else begin
      busy_q  <= 1'b0;
    end
  end

  wire [1:0]      kind    = funct_q[1:0];
  wire [XLEN-1:0] operand = funct_q[2] ? XLEN'(rs1_q) : val_q;
  wire            rcond   = (kind == 2'd1) ? (rd_q != 5'd0) : 1'b1;
  wire            wcond   = (kind == 2'd1) ? 1'b1 : (rs1_q != 5'd0);
  wire            fault   = (kind == 2'd0) || (priv_q < addr_q[9:8]) || !csr_present ||
                            (wcond && addr_q[11:10] == 2'b11);

  assign busy      = busy_q;
  assign csr_addr  = addr_q;
  assign csr_rd_en = busy_q && rcond && !fault;
  assign csr_wr_en = busy_q && wcond && !fault;

  wire [XLEN-1:0] old = csr_rd_en ? csr_rd_data : '0;

  always_comb begin
    case (kind)
      2'd2:    csr_wr_data = old | operand;
      2'd3:    csr_wr_data = old & ~operand;
      default: csr_wr_data = operand;
    endcase
  end

  logic [RD_W-1:0] old_ext;
  generate
    if (EXT > 0) begin : g_sext
      assign old_ext = {{EXT{old[XLEN-1]}}, old};
    end else begin : g_same
      assign old_ext = old;
    end
  endgenerate

  logic            rsp_q, fault_q, we_q;
  logic [RD_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_q   <= 1'b0;
      fault_q <= 1'b0;
      we_q    <= 1'b0;
      data_q  <= '0;
    end else begin
      rsp_q   <= busy_q;
      fault_q <= busy_q && fault;
      we_q    <= busy_q && !fault && (rd_q != 5'd0);
      data_q  <= busy_q ? old_ext : data_q;
    end
  end

  assign rsp_valid = rsp_q;
  assign rsp_fault = fault_q;
  assign rd_we     = we_q;
  assign rd_idx    = rd_q;
  assign rd_data   = data_q;

  a_r9_busy_then_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> rsp_valid && !busy);
  a_r9_idle_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !rsp_valid);
  a_r9_strobe_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd_en || csr_wr_en) |-> busy);
  a_r6_priv_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd_en || csr_wr_en) |-> priv_q >= csr_addr[9:8]);
  a_r7_no_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr_en |-> csr_addr[11:10] != 2'b11);
  a_r11_fault_no_we: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_valid && !rd_we);
  a_r2_write_clean: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr_en |=> rsp_valid && !rsp_fault);
endmodule

// File: tb/csr_access_ctrl_test.sv
module csr_access_ctrl_test;
  localparam int XLEN = 32;
  localparam int RD_W = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic            op_valid = 1'b0;
  logic [2:0]      op_funct = '0;
  logic [4:0]      op_rd = '0, op_rs1 = '0;
  logic [XLEN-1:0] op_rs1_val = '0;
  logic [11:0]     op_addr = '0;
  logic [1:0]      op_priv = '0;
  logic            busy, csr_rd_en, csr_wr_en, csr_present;
  logic [11:0]     csr_addr;
  logic [XLEN-1:0] csr_rd_data, csr_wr_data;
  logic            rsp_valid, rsp_fault, rd_we;
  logic [4:0]      rd_idx;
  logic [RD_W-1:0] rd_data;

  csr_access_ctrl #(.XLEN(XLEN), .RD_W(RD_W)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_funct(op_funct), .op_rd(op_rd),
    .op_rs1(op_rs1), .op_rs1_val(op_rs1_val), .op_addr(op_addr), .op_priv(op_priv),
    .busy(busy), .csr_addr(csr_addr), .csr_rd_en(csr_rd_en), .csr_rd_data(csr_rd_data),
    .csr_present(csr_present), .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rd_we(rd_we), .rd_idx(rd_idx),
    .rd_data(rd_data));

  // bank model: 0x300 machine, 0x100 supervisor, 0x000 user, 0xC00 user read-only, 0xF11 machine read-only
  logic [XLEN-1:0] bank [5];

  function automatic int bidx(input logic [11:0] a);
    case (a)
      12'h300: return 0;
      12'h100: return 1;
      12'h000: return 2;
      12'hC00: return 3;
      12'hF11: return 4;
      default: return -1;
    endcase
  endfunction

  always_comb begin
    csr_present = bidx(csr_addr) >= 0;
    csr_rd_data = csr_present ? bank[bidx(csr_addr)] : '0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      bank[0] <= 32'h8000_0001;
      bank[1] <= 32'h0000_00A5;
      bank[2] <= 32'h0000_0F0F;
      bank[3] <= 32'h1357_9BDF;
      bank[4] <= 32'hFEDC_BA98;
    end else if (csr_wr_en && bidx(csr_addr) >= 0) begin
      bank[bidx(csr_addr)] <= csr_wr_data;
    end
  end

  int checks = 0;
  int failures = 0;
  logic [70:0] exp_q [$];
  string       tag_q [$];

  task automatic chk(input string tag, input logic [70:0] act, input logic [70:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R9 actual=unexpected response expected=none");
      end else begin
        chk(tag_q.pop_front(), {rsp_fault, rd_we, rd_idx, rd_data}, exp_q.pop_front());
      end
    end
  end

  task automatic do_op(input string tag, input logic [2:0] f, input logic [4:0] rd,
                       input logic [4:0] rs1, input logic [XLEN-1:0] v,
                       input logic [11:0] a, input logic [1:0] p, input bit poke);
    int i;
    logic [1:0] k;
    logic [XLEN-1:0] opnd, old, nw;
    logic rc, wc, flt;
    logic [RD_W-1:0] ext;
    @(negedge clk);
    i = bidx(a);
    k = f[1:0];
    opnd = f[2] ? {27'd0, rs1} : v;
    rc = (k == 2'd1) ? (rd != 0) : 1'b1;
    wc = (k == 2'd1) ? 1'b1 : (rs1 != 0);
    flt = (k == 2'd0) || (p < a[9:8]) || (i < 0) || (wc && a[11:10] == 2'b11);
    old = (!flt && rc) ? bank[i] : '0;
    nw = (k == 2'd2) ? (old | opnd) : (k == 2'd3) ? (old & ~opnd) : opnd;
    ext = {{(RD_W-XLEN){old[XLEN-1]}}, old};
    exp_q.push_back({flt, !flt && rd != 0, rd, ext});
    tag_q.push_back(tag);
    op_valid = 1; op_funct = f; op_rd = rd; op_rs1 = rs1; op_rs1_val = v; op_addr = a; op_priv = p;
    @(negedge clk);
    op_valid = 0;
    if (poke) begin
      op_valid = 1; op_funct = 3'd1; op_rd = 0; op_addr = 12'h000; op_priv = 2'd3;
      op_rs1_val = 32'hDEAD_BEEF;
    end
    chk({tag, " busy"}, {70'd0, busy}, 71'd1);
    chk({tag, " strobes"}, {37'd0, csr_rd_en, csr_wr_en, flt ? 32'd0 : (wc ? csr_wr_data : 32'd0)},
        {37'd0, !flt && rc, !flt && wc, flt ? 32'd0 : (wc ? nw : 32'd0)});
    @(negedge clk);
    op_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {65'd0, busy, csr_rd_en, csr_wr_en, rsp_valid, rsp_fault, rd_we}, 71'd0);
    rst_n = 1;
    do_op("R10 swap sext", 3'd1, 5'd5, 5'd7, 32'h1234_5678, 12'h300, 2'd3, 0);
    chk("R5 swap value", {39'd0, bank[0]}, {39'd0, 32'h1234_5678});
    do_op("R2 swap rd0 no read", 3'd1, 5'd0, 5'd7, 32'h0000_0055, 12'h100, 2'd1, 0);
    chk("R2 swap wrote", {39'd0, bank[1]}, {39'd0, 32'h55});
    do_op("R7 ro read set rs1=0", 3'd2, 5'd3, 5'd0, 32'hFFFF_FFFF, 12'hC00, 2'd0, 0);
    do_op("R3 set", 3'd2, 5'd4, 5'd2, 32'h0000_00F0, 12'h000, 2'd0, 0);
    chk("R5 set value", {39'd0, bank[2]}, {39'd0, 32'h0FFF});
    do_op("R3 clear", 3'd3, 5'd6, 5'd1, 32'h0000_0678, 12'h300, 2'd3, 0);
    chk("R5 clear value", {39'd0, bank[0]}, {39'd0, 32'h1234_5000});
    do_op("R4 swapi", 3'd5, 5'd0, 5'd31, 32'hFFFF_FFFF, 12'h000, 2'd0, 0);
    chk("R4 zext imm", {39'd0, bank[2]}, {39'd0, 32'h1F});
    do_op("R4 seti imm0 on ro", 3'd6, 5'd8, 5'd0, 32'hFFFF_FFFF, 12'hF11, 2'd3, 0);
    do_op("R4 cleari", 3'd7, 5'd9, 5'd5, 32'h0, 12'h300, 2'd3, 0);
    chk("R5 cleari value", {39'd0, bank[0]}, {39'd0, 32'h1234_5000});
    do_op("R7 ro seti fault", 3'd6, 5'd2, 5'd3, 32'h0, 12'hC00, 2'd3, 0);
    do_op("R7 ro set fault", 3'd2, 5'd2, 5'd4, 32'h1, 12'hF11, 2'd3, 0);
    chk("R7 ro kept", {39'd0, bank[4]}, {39'd0, 32'hFEDC_BA98});
    do_op("R6 priv fault", 3'd2, 5'd2, 5'd0, 32'h0, 12'h300, 2'd1, 0);
    do_op("R6 user on sup", 3'd1, 5'd2, 5'd1, 32'h7, 12'h100, 2'd0, 0);
    chk("R6 sup kept", {39'd0, bank[1]}, {39'd0, 32'h55});
    do_op("R8 absent", 3'd2, 5'd2, 5'd0, 32'h0, 12'h7FF, 2'd3, 0);
    do_op("R11 code0", 3'd0, 5'd2, 5'd1, 32'h0, 12'h000, 2'd3, 0);
    do_op("R11 code4", 3'd4, 5'd2, 5'd1, 32'h0, 12'h000, 2'd3, 0);
    chk("R11 user kept", {39'd0, bank[2]}, {39'd0, 32'h1F});
    do_op("R9 busy ignore", 3'd2, 5'd1, 5'd0, 32'h0, 12'h100, 2'd1, 1);
    repeat (3) @(negedge clk);
    chk("R9 ignored op", {39'd0, bank[2]}, {39'd0, 32'h1F});
    chk("R9 queue drained", 71'(exp_q.size()), 71'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule